// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides the power state of a small 8-bit microcontroller core. Software sets one of two mode bits in a power-control register to put the core to sleep: the lighter sleep halts only the CPU clock and leaves timers, serial ports and the oscillator running. The deeper sleep halts every internal clock and the crystal oscillator. While the core sleeps, the block watches interrupt request lines and power-fail indications. It returns the core to running when a source that is valid for the current sleep depth fires.

A software bit in a separate configuration register chooses whether the reference used by the supply monitor stays powered during the deep sleep. Keeping it powered costs standby current. In exchange, power-fail events become legal wake sources. In running and light sleep the reference is always on. On every wake, hardware clears the mode bits and sends a one-cycle pulse toward the interrupt controller.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset, cpu_clk_en, periph_clk_en, osc_en and ref_en are 1, mode_q is 00, refkeep_q is 0 and wake_pulse is 0.
- R2: A write to the power-control register in the running state takes effect on the next cycle. If bit 1 is set, the block enters Stop, even when bit 0 is also set. If only bit 0 is set, it enters Idle. If both bits are 0, it stays running. mode_q holds the written value while asleep.
- R3: In Idle, cpu_clk_en is 0 while periph_clk_en and osc_en stay 1.
- R4: In Stop, cpu_clk_en, periph_clk_en and osc_en are all 0.
- R5: In Idle, any one of these wakes the core on the next cycle: an internal interrupt line, an external interrupt line, the real-time-clock interrupt, the power-fail interrupt or the power-fail reset.
- R6: In Stop, an external interrupt or the real-time-clock interrupt wakes the core on the next cycle. Internal interrupt lines never wake it from Stop.
- R7: Writing the configuration register in the running state stores its data bit in refkeep_q. In Stop, ref_en equals refkeep_q. In running and Idle, ref_en is 1 whatever refkeep_q holds.
- R8: In Stop, the power-fail interrupt and the power-fail reset wake the core only when refkeep_q is 1. When refkeep_q is 0 they are ignored.
- R9: On a wake, mode_q returns to 00, the clock enables return to 1, and wake_pulse is 1 for exactly the first running cycle.
- R10: Writes to either register while asleep are ignored.
- R11: Asserting rst_n in any state returns the block to the R1 state at once, including clearing refkeep_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_wr | input | 1 | Write strobe, power-control register |
| pwr_wdata | input | 2 | Mode bits: bit 0 Idle, bit 1 Stop |
| xcfg_wr | input | 1 | Write strobe, configuration register |
| xcfg_wdata | input | 1 | Keep-reference-in-Stop bit |
| irq_int | input | N_INT | Enabled internal interrupts (timer, serial, watchdog) |
| irq_ext | input | N_EXT | Enabled external interrupts |
| irq_rtc | input | 1 | Real-time-clock interrupt |
| pf_irq | input | 1 | Power-fail interrupt |
| pf_rst | input | 1 | Power-fail reset request |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| periph_clk_en | output | 1 | Timer and serial clock gate enable |
| osc_en | output | 1 | Crystal oscillator enable |
| ref_en | output | 1 | Supply-monitor reference enable |
| wake_pulse | output | 1 | One-cycle wake indication |
| mode_q | output | 2 | Power-control mode bits readback |
| refkeep_q | output | 1 | Configuration bit readback |

## Verification
A wrong state register appears on the clock enables in the cycle after the faulty transition. A core left in Stop keeps osc_en low, and a core dropped into Idle by mistake shows cpu_clk_en low while periph_clk_en stays high. A wrong wake qualification appears one cycle after the offending request: either wake_pulse rises and mode_q clears when they should not, or they stay put when they should change. A corrupted configuration bit is visible at once on refkeep_q and on ref_en during Stop. The sweep drives every wake source in every mode and with both reference settings, so each of these faults fails a check within a few cycles.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_STOP = 2'd2
  } pm_state_t;

  localparam int MODE_W        = 2;
  localparam int MODE_IDLE_BIT = 0;
  localparam int MODE_STOP_BIT = 1;
endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual
  import pwr_mode_pkg::*;
#(
  parameter int N_INT = 3,
  parameter int N_EXT = 2
) (
  input  pm_state_t        state,
  input  logic [N_INT-1:0] irq_int,
  input  logic [N_EXT-1:0] irq_ext,
  input  logic             irq_rtc,
  input  logic             pf_irq,
  input  logic             pf_rst,
  input  logic             refkeep,
  output logic             wake
);
  logic any_int;
  logic any_ext;
  logic any_pf;

  assign any_int = |irq_int;
  assign any_ext = |irq_ext;
  assign any_pf  = pf_irq | pf_rst;

  // Clocked sources can only wake from Idle; Stop accepts asynchronous ones,
  // plus power-fail events when the reference is kept alive.
  always_comb begin
    unique case (state)
      PM_IDLE: wake = any_int | any_ext | irq_rtc | any_pf;
      PM_STOP: wake = any_ext | irq_rtc | (refkeep & any_pf);
      default: wake = 1'b0;
    endcase
  end
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_wr,
  input  logic [MODE_W-1:0] pwr_wdata,
  input  logic              wake,
  output pm_state_t         state,
  output logic [MODE_W-1:0] mode_q,
  output logic              wake_pulse
);
  pm_state_t         state_q, state_d;
  logic [MODE_W-1:0] mode_d;
  logic              pulse_d;
  logic              upd_en;

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    pulse_d = 1'b0;
    unique case (state_q)
      PM_RUN: begin
        if (pwr_wr) begin
          if (pwr_wdata[MODE_STOP_BIT]) begin
            state_d = PM_STOP;
            mode_d  = pwr_wdata;
          end else if (pwr_wdata[MODE_IDLE_BIT]) begin
            state_d = PM_IDLE;
            mode_d  = pwr_wdata;
          end
        end
      end
      PM_IDLE, PM_STOP: begin
        if (wake) begin
          state_d = PM_RUN;
          mode_d  = '0;
          pulse_d = 1'b1;
        end
      end
      default: begin
        state_d = PM_RUN;
        mode_d  = '0;
      end
    endcase
  end

  assign upd_en = (state_d != state_q) || (mode_d != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PM_RUN;
      mode_q  <= '0;
    end else if (upd_en) begin
      state_q <= state_d;
      mode_q  <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_pulse <= 1'b0;
    else        wake_pulse <= pulse_d;
  end

  assign state = state_q;
endmodule

// File: rtl/pwr_gate_dec.sv
module pwr_gate_dec
  import pwr_mode_pkg::*;
(
  input  pm_state_t state,
  input  logic      refkeep,
  output logic      cpu_clk_en,
  output logic      periph_clk_en,
  output logic      osc_en,
  output logic      ref_en
);
  logic in_stop;

  assign in_stop       = (state == PM_STOP);
  assign cpu_clk_en    = (state == PM_RUN);
  assign periph_clk_en = !in_stop;
  assign osc_en        = !in_stop;
  assign ref_en        = !in_stop || refkeep;
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int N_INT   = 3,
  parameter int N_EXT   = 2,
  parameter int SYNC_FF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_wr,
  input  logic [1:0]       pwr_wdata,
  input  logic             xcfg_wr,
  input  logic             xcfg_wdata,
  input  logic [N_INT-1:0] irq_int,
  input  logic [N_EXT-1:0] irq_ext,
  input  logic             irq_rtc,
  input  logic             pf_irq,
  input  logic             pf_rst,
  output logic             cpu_clk_en,
  output logic             periph_clk_en,
  output logic             osc_en,
  output logic             ref_en,
  output logic             wake_pulse,
  output logic [1:0]       mode_q,
  output logic             refkeep_q
);
  // Reset: asserted asynchronously, released after SYNC_FF clock edges.
  logic [SYNC_FF-1:0] rst_pipe;
  logic               rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_FF-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_FF-1];

  pm_state_t state;
  logic      wake;
  logic      refkeep_d;
  logic      refkeep_en;

  // Configuration bit: only writable while the CPU runs.
  assign refkeep_en = xcfg_wr && (state == PM_RUN);
  assign refkeep_d  = xcfg_wdata;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)     refkeep_q <= 1'b0;
    else if (refkeep_en) refkeep_q <= refkeep_d;
  end

  pwr_wake_qual #(.N_INT(N_INT), .N_EXT(N_EXT)) u_qual (
    .state   (state),
    .irq_int (irq_int),
    .irq_ext (irq_ext),
    .irq_rtc (irq_rtc),
    .pf_irq  (pf_irq),
    .pf_rst  (pf_rst),
    .refkeep (refkeep_q),
    .wake    (wake)
  );

  pwr_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .pwr_wr     (pwr_wr),
    .pwr_wdata  (pwr_wdata),
    .wake       (wake),
    .state      (state),
    .mode_q     (mode_q),
    .wake_pulse (wake_pulse)
  );

  pwr_gate_dec u_dec (
    .state         (state),
    .refkeep       (refkeep_q),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .osc_en        (osc_en),
    .ref_en        (ref_en)
  );
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk #(
  parameter int N_INT = 3,
  parameter int N_EXT = 2
) (
  input logic             clk,
  input logic             rst_ok_n,
  input logic             pwr_wr,
  input logic [1:0]       pwr_wdata,
  input logic [N_INT-1:0] irq_int,
  input logic [N_EXT-1:0] irq_ext,
  input logic             irq_rtc,
  input logic             pf_irq,
  input logic             pf_rst,
  input logic             cpu_clk_en,
  input logic             periph_clk_en,
  input logic             osc_en,
  input logic             ref_en,
  input logic             wake_pulse,
  input logic [1:0]       mode_q,
  input logic             refkeep_q
);
  a_r2_stop_priority: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (cpu_clk_en && pwr_wr && pwr_wdata == 2'b11) |=> (!osc_en && mode_q == 2'b11));

  a_r3_idle_gates: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (mode_q == 2'b01) |-> (!cpu_clk_en && periph_clk_en && osc_en));

  a_r4_stop_gates: assert property (@(posedge clk) disable iff (!rst_ok_n)
    mode_q[1] |-> (!cpu_clk_en && !periph_clk_en && !osc_en));

  // R6 and R8: without an allowed source, Stop persists.
  a_r6_stop_holds: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (mode_q[1] && !(|irq_ext) && !irq_rtc && !(refkeep_q && (pf_irq || pf_rst)))
    |=> mode_q[1]);

  a_r7_ref_awake: assert property (@(posedge clk) disable iff (!rst_ok_n)
    osc_en |-> ref_en);

  a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_ok_n)
    wake_pulse |=> !wake_pulse);

  a_r9_pulse_running: assert property (@(posedge clk) disable iff (!rst_ok_n)
    wake_pulse |-> (cpu_clk_en && mode_q == 2'b00 && $past(mode_q) != 2'b00));
endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(.N_INT(N_INT), .N_EXT(N_EXT)) u_chk (
  .clk           (clk),
  .rst_ok_n      (rst_sync_n),
  .pwr_wr        (pwr_wr),
  .pwr_wdata     (pwr_wdata),
  .irq_int       (irq_int),
  .irq_ext       (irq_ext),
  .irq_rtc       (irq_rtc),
  .pf_irq        (pf_irq),
  .pf_rst        (pf_rst),
  .cpu_clk_en    (cpu_clk_en),
  .periph_clk_en (periph_clk_en),
  .osc_en        (osc_en),
  .ref_en        (ref_en),
  .wake_pulse    (wake_pulse),
  .mode_q        (mode_q),
  .refkeep_q     (refkeep_q)
);

// File: tb/pwr_mode_seq_test.sv
`timescale 1ns/1ps
module pwr_mode_seq_test;
  localparam int N_INT = 3;
  localparam int N_EXT = 2;
  localparam int N_SRC = N_INT + N_EXT + 3;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             pwr_wr;
  logic [1:0]       pwr_wdata;
  logic             xcfg_wr;
  logic             xcfg_wdata;
  logic [N_INT-1:0] irq_int;
  logic [N_EXT-1:0] irq_ext;
  logic             irq_rtc, pf_irq, pf_rst;
  logic             cpu_clk_en, periph_clk_en, osc_en, ref_en, wake_pulse;
  logic [1:0]       mode_q;
  logic             refkeep_q;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  pwr_mode_seq #(.N_INT(N_INT), .N_EXT(N_EXT)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_wr(pwr_wr), .pwr_wdata(pwr_wdata),
    .xcfg_wr(xcfg_wr), .xcfg_wdata(xcfg_wdata), .irq_int(irq_int),
    .irq_ext(irq_ext), .irq_rtc(irq_rtc), .pf_irq(pf_irq), .pf_rst(pf_rst),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en),
    .ref_en(ref_en), .wake_pulse(wake_pulse), .mode_q(mode_q),
    .refkeep_q(refkeep_q)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Source index: 0..N_INT-1 internal, then external, then rtc, pf_irq, pf_rst.
  task automatic drive_src(input int s, input logic v);
    if (s < N_INT) irq_int[s] = v;
    else if (s < N_INT + N_EXT) irq_ext[s-N_INT] = v;
    else if (s == N_INT + N_EXT) irq_rtc = v;
    else if (s == N_INT + N_EXT + 1) pf_irq = v;
    else pf_rst = v;
  endtask

  task automatic set_refkeep(input logic v);
    xcfg_wr = 1'b1; xcfg_wdata = v;
    @(negedge clk);
    xcfg_wr = 1'b0; xcfg_wdata = 1'b0;
  endtask

  task automatic write_mode(input logic [1:0] m);
    pwr_wr = 1'b1; pwr_wdata = m;
    @(negedge clk);
    pwr_wr = 1'b0; pwr_wdata = 2'b00;
  endtask

  task automatic wake_ext();
    irq_ext[0] = 1'b1;
    @(negedge clk);
    irq_ext[0] = 1'b0;
    check("R9 wake pulse after ext", int'(wake_pulse), 1);
    @(negedge clk);
    check("R9 pulse one cycle", int'(wake_pulse), 0);
  endtask

  initial begin
    rst_n = 1'b0; pwr_wr = 0; pwr_wdata = 0; xcfg_wr = 0; xcfg_wdata = 0;
    irq_int = '0; irq_ext = '0; irq_rtc = 0; pf_irq = 0; pf_rst = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R1 cpu_clk_en", int'(cpu_clk_en), 1);
    check("R1 periph_clk_en", int'(periph_clk_en), 1);
    check("R1 osc_en", int'(osc_en), 1);
    check("R1 ref_en", int'(ref_en), 1);
    check("R1 mode_q", int'(mode_q), 0);
    check("R1 refkeep_q", int'(refkeep_q), 0);
    check("R1 wake_pulse", int'(wake_pulse), 0);

    for (int rk = 0; rk < 2; rk++) begin
      set_refkeep(rk[0]);
      check("R7 refkeep stored", int'(refkeep_q), rk);
      for (int m = 0; m < 4; m++) begin
        for (int s = 0; s < N_SRC; s++) begin
          logic is_stop, is_idle, woke;
          is_stop = m[1];
          is_idle = (m == 1);
          write_mode(m[1:0]);
          if (!is_stop && !is_idle) begin
            check("R2 no sleep on 00", int'(cpu_clk_en), 1);
            check("R2 mode stays 00", int'(mode_q), 0);
            continue;
          end
          check("R2 mode latched", int'(mode_q), m);
          check(is_stop ? "R4 cpu off" : "R3 cpu off", int'(cpu_clk_en), 0);
          check(is_stop ? "R4 periph off" : "R3 periph on", int'(periph_clk_en), is_stop ? 0 : 1);
          check(is_stop ? "R4 osc off" : "R3 osc on", int'(osc_en), is_stop ? 0 : 1);
          check("R7 ref_en", int'(ref_en), is_stop ? rk : 1);
          if (is_idle) woke = 1'b1;
          else if (s < N_INT) woke = 1'b0;
          else if (s < N_INT + N_EXT + 1) woke = 1'b1;
          else woke = rk[0];
          drive_src(s, 1'b1);
          @(negedge clk);
          drive_src(s, 1'b0);
          if (is_idle) check("R5 idle wake", int'(cpu_clk_en), 1);
          else if (s < N_INT + N_EXT + 1) check("R6 stop wake by source", int'(cpu_clk_en), woke ? 1 : 0);
          else check("R8 power-fail wake from stop", int'(cpu_clk_en), woke ? 1 : 0);
          if (woke) begin
            check("R9 wake pulse", int'(wake_pulse), 1);
            check("R9 mode cleared", int'(mode_q), 0);
            check("R9 osc back", int'(osc_en), 1);
            @(negedge clk);
            check("R9 pulse one cycle", int'(wake_pulse), 0);
          end else begin
            check("R6 no pulse", int'(wake_pulse), 0);
            check("R6 mode kept", int'(mode_q), m);
            wake_ext();
          end
        end
      end
    end

    // R10: writes while asleep are ignored.
    set_refkeep(1'b0);
    write_mode(2'b01);
    pwr_wr = 1'b1; pwr_wdata = 2'b10; xcfg_wr = 1'b1; xcfg_wdata = 1'b1;
    @(negedge clk);
    pwr_wr = 1'b0; pwr_wdata = 2'b00; xcfg_wr = 1'b0; xcfg_wdata = 1'b0;
    check("R10 mode write ignored", int'(mode_q), 1);
    check("R10 osc still on", int'(osc_en), 1);
    check("R10 cfg write ignored", int'(refkeep_q), 0);
    wake_ext();
    check("R10 cfg after wake", int'(refkeep_q), 0);

    // R11: asynchronous reset out of Stop.
    set_refkeep(1'b1);
    write_mode(2'b10);
    check("R11 pre-reset stop", int'(osc_en), 0);
    #1 rst_n = 1'b0;
    #0.5;
    check("R11 cpu_clk_en", int'(cpu_clk_en), 1);
    check("R11 osc_en", int'(osc_en), 1);
    check("R11 mode_q", int'(mode_q), 0);
    check("R11 refkeep_q", int'(refkeep_q), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 after release", int'(cpu_clk_en), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule